// File: doc/BRIEF.md
# Packet Gap-Inserting Circular Byte Buffer

This block sits between an input-side byte stream and an output-side processing chain. Bytes arrive on a write port whenever the source has them. They are held in a circular store and leave one per read enable, so that jitter on the arrival side never reaches the continuous output side. Each stored byte keeps a start-of-packet marker next to it.

In gap-inserting mode the input carries bare packets of `PKT_LEN` bytes. After every `PKT_LEN` data bytes, the read side emits `GAP_LEN` placeholder slots. During these slots the output byte is zero and a gap flag is raised. A later encoder places its check bytes in those slots. The placeholder slots consume read enables but take nothing from the buffer. In pass-through mode the input already holds the reserved positions, and every read enable takes a stored byte with no insertion.

A write that arrives at a full buffer and a read enable that finds no data are both reported on one-cycle interrupt pulses. Each pulse has its own mask input.

Top module: `rs_gap_fifo`

## Requirements
- R1: Stored bytes leave in the order they were accepted. Up to `DEPTH` bytes can be held, and the storage wraps around circularly.
- R2: A write with `wr_valid`=1 while the buffer holds `DEPTH` bytes is dropped. `ovf_irq` is high for exactly the following cycle when `ovf_mask` is 0.
- R3: With `rd_en`=1 outside a gap slot and an empty buffer, no output is produced (`rd_valid`=0 in the next cycle) and the packet position is unchanged. `udf_irq` is high for exactly the following cycle when `udf_mask` is 0.
- R4: The output is registered. A read enable in cycle t gives its result in cycle t+1. `rd_valid` is 0 in any cycle that follows a cycle with `rd_en`=0.
- R5: With `gapless_mode`=1, after `PKT_LEN` data bytes the next `GAP_LEN` read enables each yield `rd_valid`=1, `rd_gap`=1 and `rd_data`=0. No buffer entry is taken during these slots.
- R6: With `gapless_mode`=0, every read enable takes a stored byte if one is present, and `rd_gap` stays 0. The packet position is reset to the first byte.
- R7: `rd_sop` repeats the marker stored with the byte being output. A byte stored with its marker set restarts the packet count, so it is counted as byte one of a new packet.
- R8: While a mask input is 1, its interrupt output stays 0 whatever events occur.
- R9: During and right after synchronous active-low reset, the buffer is empty and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| gapless_mode | input | 1 | 1: insert `GAP_LEN` slots after each `PKT_LEN` bytes; 0: pass-through |
| wr_data | input | 8 | Input byte |
| wr_valid | input | 1 | Input byte is present this cycle |
| wr_sop | input | 1 | Input byte is the first of a packet |
| rd_en | input | 1 | Output side requests one byte or slot |
| ovf_mask | input | 1 | Suppresses the overflow interrupt |
| udf_mask | input | 1 | Suppresses the underflow interrupt |
| rd_data | output | 8 | Output byte (0 in gap slots) |
| rd_valid | output | 1 | rd_data carries a byte or gap slot |
| rd_gap | output | 1 | Current output is an inserted placeholder slot |
| rd_sop | output | 1 | Current output byte starts a packet |
| ovf_irq | output | 1 | One-cycle pulse: a write was dropped |
| udf_irq | output | 1 | One-cycle pulse: a read found no data |

## Verification
The bench builds the block with `DEPTH`=8, `PKT_LEN`=6 and `GAP_LEN`=3. With these values the buffer fills in a few writes and both pointers wrap many times. Dozens of packet-to-gap and gap-to-packet transitions happen within a few hundred cycles. The small packet length also makes it cheap to place a start marker in the middle of a packet and follow the count restart through to the next gap. A reference model built from queues compares every output on every clock, through full, empty, masked and mode-switch episodes.

// File: rtl/rsgf_pkg.sv
// Shared types for the gap-inserting circular buffer.
// Assumes byte-wide data; one marker bit travels with each byte.
package rsgf_pkg;
    parameter int BYTE_W = 8;

    typedef struct packed {
        logic              sop;
        logic [BYTE_W-1:0] data;
    } slot_t;

    typedef enum logic {
        PH_DATA = 1'b0,
        PH_GAP  = 1'b1
    } phase_t;
endpackage

// File: rtl/rsgf_ring.sv
// Circular store of DEPTH slots with independent write and read pointers.
// Assumes: a push is refused when full, a pop is refused when empty;
// the head slot is read combinationally; DEPTH need not be a power of two.
module rsgf_ring
    import rsgf_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_req,
    input  slot_t wr_slot,
    input  logic  rd_req,
    output slot_t head,
    output logic  empty,
    output logic  full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    slot_t          mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW-1:0]  rptr;
    logic [CW-1:0]  count;
    logic           push;
    logic           pop;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign push  = wr_req && !full;
    assign pop   = rd_req && !empty;
    assign head  = mem[rptr];

    // Store accepted slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= wr_slot;
        end
    end

    // Advance the pointers with wrap at DEPTH-1 and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            end
            if (pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            end
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rsgf_seq.sv
// Read-side sequencer: serves one byte or placeholder slot per read enable.
// Assumes: in gap-inserting mode, PKT_LEN data bytes are followed by GAP_LEN
// zero slots that take nothing from the store; a stored start marker restarts
// the packet count; pass-through mode holds the count at the first byte.
module rsgf_seq
    import rsgf_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int GAP_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              gapless,
    input  logic              empty,
    input  slot_t             head,
    output logic              pop,
    output logic              udf_ev,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_gap,
    output logic              rd_sop
);
    localparam int PW = $clog2(PKT_LEN + 1);
    localparam int GW = $clog2(GAP_LEN + 1);

    phase_t         phase;
    logic [PW-1:0]  pos;
    logic [GW-1:0]  gcnt;
    logic           in_gap;
    logic           want_data;
    logic           gap_slot;
    logic [PW-1:0]  eff_pos;
    logic           last_byte;
    logic           last_gap;

    assign in_gap    = gapless && (phase == PH_GAP);
    assign want_data = rd_en && !in_gap;
    assign pop       = want_data && !empty;
    assign udf_ev    = want_data && empty;
    assign gap_slot  = rd_en && in_gap;
    assign eff_pos   = head.sop ? '0 : pos;
    assign last_byte = (eff_pos == PW'(PKT_LEN - 1));
    assign last_gap  = (gcnt == GW'(GAP_LEN - 1));

    // Register the output byte, its flags and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            rd_gap   <= 1'b0;
            rd_sop   <= 1'b0;
        end else begin
            rd_valid <= pop || gap_slot;
            rd_gap   <= gap_slot;
            rd_sop   <= pop && head.sop;
            if (pop) begin
                rd_data <= head.data;
            end else if (gap_slot) begin
                rd_data <= '0;
            end
        end
    end

    // Track the packet position and the gap slot count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DATA;
            pos   <= '0;
            gcnt  <= '0;
        end else if (!gapless) begin
            phase <= PH_DATA;
            pos   <= '0;
            gcnt  <= '0;
        end else if (pop) begin
            if (last_byte) begin
                phase <= PH_GAP;
                pos   <= '0;
                gcnt  <= '0;
            end else begin
                pos <= eff_pos + PW'(1);
            end
        end else if (gap_slot) begin
            if (last_gap) begin
                phase <= PH_DATA;
                gcnt  <= '0;
            end else begin
                gcnt <= gcnt + GW'(1);
            end
        end
    end
endmodule

// File: rtl/rsgf_irq.sv
// Maskable event flags: each event becomes a one-cycle registered pulse.
// Assumes events are single-cycle strobes and masks are level inputs.
module rsgf_irq #(
    parameter int NUM = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] ev,
    input  logic [NUM-1:0] mask,
    output logic [NUM-1:0] irq
);
    for (genvar i = 0; i < NUM; i++) begin : g_flag
        logic q;
        // Register one masked event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else begin
                q <= ev[i] && !mask[i];
            end
        end
        assign irq[i] = q;
    end
endmodule

// File: rtl/rs_gap_fifo.sv
// Top level: circular byte buffer with packet gap insertion on the read side.
// Assumes one clock for both ports; a write into a full buffer is dropped;
// the input reserves no gap positions while gapless_mode is 1.
module rs_gap_fifo
    import rsgf_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int PKT_LEN = 188,
    parameter int GAP_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gapless_mode,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              wr_sop,
    input  logic              rd_en,
    input  logic              ovf_mask,
    input  logic              udf_mask,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_gap,
    output logic              rd_sop,
    output logic              ovf_irq,
    output logic              udf_irq
);
    slot_t      wr_slot;
    slot_t      head;
    logic       buf_empty;
    logic       buf_full;
    logic       pop;
    logic       udf_ev;
    logic       ovf_ev;
    logic [1:0] irq_vec;

    assign wr_slot = '{sop: wr_sop, data: wr_data};
    assign ovf_ev  = wr_valid && buf_full;

    rsgf_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (wr_valid),
        .wr_slot (wr_slot),
        .rd_req  (pop),
        .head    (head),
        .empty   (buf_empty),
        .full    (buf_full)
    );

    rsgf_seq #(.PKT_LEN(PKT_LEN), .GAP_LEN(GAP_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .gapless  (gapless_mode),
        .empty    (buf_empty),
        .head     (head),
        .pop      (pop),
        .udf_ev   (udf_ev),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_gap   (rd_gap),
        .rd_sop   (rd_sop)
    );

    rsgf_irq #(.NUM(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    ({udf_ev, ovf_ev}),
        .mask  ({udf_mask, ovf_mask}),
        .irq   (irq_vec)
    );

    assign ovf_irq = irq_vec[0];
    assign udf_irq = irq_vec[1];
endmodule

// File: rtl/rsgf_chk.sv
// Property checker for rs_gap_fifo, attached with bind.
// Assumes it observes top-level ports plus the store's full indication.
module rsgf_chk
    import rsgf_pkg::*;
#(
    parameter int GAP_LEN = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gapless_mode,
    input logic              wr_valid,
    input logic              rd_en,
    input logic              ovf_mask,
    input logic              udf_mask,
    input logic [BYTE_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_gap,
    input logic              ovf_irq,
    input logic              udf_irq,
    input logic              buf_full
);
    localparam int RW = $clog2(GAP_LEN + 1) + 1;
    logic [RW-1:0] gap_run;

    // R5: a placeholder slot is a valid zero byte.
    a_r5_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_gap |-> (rd_valid && rd_data == '0));

    // R6: pass-through mode never produces a placeholder.
    a_r6_no_gap_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !gapless_mode |=> !rd_gap);

    // R4: no output follows a cycle without a read enable.
    a_r4_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2: a write at full raises the unmasked overflow pulse.
    a_r2_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && buf_full && !ovf_mask) |=> ovf_irq);

    // R2: overflow pulse only after a write met a full store.
    a_r2_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(wr_valid && buf_full));

    // R3: an underflow pulse coincides with no output after a read enable.
    a_r3_udf_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        udf_irq |-> ($past(rd_en) && !rd_valid));

    // R8: masks hold their interrupt low.
    a_r8_ovf_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_mask |=> !ovf_irq);
    a_r8_udf_masked: assert property (@(posedge clk) disable iff (!rst_n)
        udf_mask |=> !udf_irq);

    // Count consecutive placeholder outputs between data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_run <= '0;
        end else if (rd_valid && rd_gap) begin
            gap_run <= gap_run + RW'(1);
        end else if (rd_valid) begin
            gap_run <= '0;
        end
    end

    // R5: a run of placeholders never exceeds GAP_LEN.
    always_ff @(posedge clk) begin
        if (rst_n && rd_valid && rd_gap) begin
            a_r5_gap_run: assert (int'(gap_run) < GAP_LEN)
                else $error("gap run too long");
        end
    end
endmodule

bind rs_gap_fifo rsgf_chk #(.GAP_LEN(GAP_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gapless_mode (gapless_mode),
    .wr_valid     (wr_valid),
    .rd_en        (rd_en),
    .ovf_mask     (ovf_mask),
    .udf_mask     (udf_mask),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_gap       (rd_gap),
    .ovf_irq      (ovf_irq),
    .udf_irq      (udf_irq),
    .buf_full     (buf_full)
);

// File: tb/sim_rs_gap_fifo.sv
// Bench: queue-based reference model compared with the outputs on every clock.
module sim_rs_gap_fifo;
    localparam int DEPTH = 8;
    localparam int PKT   = 6;
    localparam int GAP   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       gapless_mode = 1'b1;
    logic [7:0] wr_data = '0;
    logic       wr_valid = 1'b0;
    logic       wr_sop = 1'b0;
    logic       rd_en = 1'b0;
    logic       ovf_mask = 1'b0;
    logic       udf_mask = 1'b0;
    logic [7:0] rd_data;
    logic       rd_valid, rd_gap, rd_sop, ovf_irq, udf_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int phase_id = 0;
    int gaps_seen = 0, ovf_seen = 0, udf_seen = 0;
    int gaps_passthru = 0, masked_irqs = 0, sop_seen = 0;
    bit done = 0;

    // Reference model state
    logic [8:0] q[$];
    int  pos = 0, gcnt = 0, sz = 0;
    bit  in_gap = 0, udf = 0;
    logic [8:0] s;
    logic [7:0] e_data = '0;
    logic e_valid = 0, e_gap = 0, e_sop = 0, e_ovf = 0, e_udf = 0;

    rs_gap_fifo #(.DEPTH(DEPTH), .PKT_LEN(PKT), .GAP_LEN(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .gapless_mode(gapless_mode),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_sop(wr_sop),
        .rd_en(rd_en), .ovf_mask(ovf_mask), .udf_mask(udf_mask),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_gap(rd_gap),
        .rd_sop(rd_sop), .ovf_irq(ovf_irq), .udf_irq(udf_irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s phase %0d: actual %0d expected %0d", tag, phase_id, act, exp);
        end
    endtask

    // Reference model, advanced at each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); pos = 0; gcnt = 0; in_gap = 0;
            e_data = 0; e_valid = 0; e_gap = 0; e_sop = 0; e_ovf = 0; e_udf = 0;
        end else begin
            sz = q.size();
            udf = 0; e_valid = 0; e_gap = 0; e_sop = 0;
            if (rd_en) begin
                if (gapless_mode && in_gap) begin
                    e_valid = 1; e_gap = 1; e_data = 0; gcnt++;
                    if (gcnt == GAP) begin in_gap = 0; gcnt = 0; end
                end else if (sz == 0) begin
                    udf = 1;
                end else begin
                    s = q.pop_front();
                    e_valid = 1; e_data = s[7:0]; e_sop = s[8];
                    if (s[8]) pos = 0;
                    if (pos == PKT - 1) begin in_gap = 1; pos = 0; gcnt = 0; end
                    else pos++;
                end
            end
            if (wr_valid && sz < DEPTH) q.push_back({wr_sop, wr_data});
            if (!gapless_mode) begin in_gap = 0; pos = 0; gcnt = 0; end
            e_ovf = wr_valid && (sz == DEPTH) && !ovf_mask;
            e_udf = udf && !udf_mask;
        end
    end

    // Compare every output with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R4 valid", rd_valid, e_valid);
            check("R5 gap", rd_gap, e_gap);
            check("R7 sop", rd_sop, e_sop);
            check("R2 ovf", ovf_irq, e_ovf);
            check("R3 udf", udf_irq, e_udf);
            if (e_valid) check("R1 data", rd_data, e_data);
            if (rd_gap) gaps_seen++;
            if (ovf_irq) ovf_seen++;
            if (udf_irq) udf_seen++;
            if (phase_id == 5 && !gapless_mode && rd_gap) gaps_passthru++;
            if (phase_id == 6 && rd_sop) sop_seen++;
            if ((ovf_mask && ovf_irq) || (udf_mask && udf_irq)) masked_irqs++;
        end
    end

    task automatic step(input logic wv, input logic ws, input logic [7:0] wd, input logic re);
        @(negedge clk);
        #1;
        wr_valid = wv; wr_sop = ws; wr_data = wd; rd_en = re;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int wb;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 rd_valid", rd_valid, 0);
        check("R9 rd_data", rd_data, 0);
        check("R9 ovf_irq", ovf_irq, 0);
        check("R9 udf_irq", udf_irq, 0);
        #1 rst_n = 1'b1;

        // Phase 2: streaming with gap insertion (R5, R1)
        phase_id = 2; wb = 0;
        for (int i = 0; i < 180; i++) begin
            if (i % 3 != 0) begin
                step(1, (wb % PKT) == 0, 8'(wb * 7 + 3), i >= 5);
                wb++;
            end else begin
                step(0, 0, 8'h00, i >= 5);
            end
        end
        check("R5 gaps inserted", int'(gaps_seen > 0), 1);

        // Phase 3: fill past full (R2), then masked (R8)
        phase_id = 3;
        for (int i = 0; i < 14; i++) step(1, 0, 8'(8'hA0 + i), 0);
        step(0, 0, 8'h00, 0);
        check("R2 overflow seen", int'(ovf_seen > 0), 1);
        ovf_mask = 1'b1;
        for (int i = 0; i < 4; i++) step(1, 0, 8'(8'hC0 + i), 0);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        ovf_mask = 1'b0;

        // Phase 4: drain past empty (R3), then masked (R8)
        phase_id = 4;
        for (int i = 0; i < 20; i++) step(0, 0, 8'h00, 1);
        check("R3 underflow seen", int'(udf_seen > 0), 1);
        udf_mask = 1'b1;
        for (int i = 0; i < 6; i++) step(0, 0, 8'h00, 1);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        udf_mask = 1'b0;
        check("R8 masked interrupts", masked_irqs, 0);

        // Phase 5: pass-through mode (R6)
        phase_id = 5;
        step(0, 0, 8'h00, 0);
        gapless_mode = 1'b0;
        for (int i = 0; i < 40; i++) step(i % 4 != 3, (i % 17) == 0, 8'(i + 50), i > 2);
        for (int i = 0; i < 12; i++) step(0, 0, 8'h00, 1);
        check("R6 no gaps in pass-through", gaps_passthru, 0);

        // Phase 6: start marker mid-packet restarts the count (R7)
        phase_id = 6;
        gapless_mode = 1'b1;
        step(1, 1, 8'h11, 0);
        step(1, 0, 8'h12, 0);
        step(1, 0, 8'h13, 0);
        for (int i = 0; i < PKT; i++) step(1, i == 0, 8'(8'h21 + i), 0);
        for (int i = 0; i < 16; i++) step(0, 0, 8'h00, 1);
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'h00, 0);
        check("R7 start markers", sop_seen, 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule